// File: doc/BRIEF.md
# Banked Control Register File for a Multi-Channel Analog Output Card

This block is the host-visible register file of an analog output card. A 16-bit synchronous bus reaches it through a 32-byte window. Three configuration registers are held here. The status word shows FIFO levels and three event flags. An 8-bit digital port with nibble-wide drive enables sits in the same window, along with one 12-bit data register for each output channel. The converters, the sample FIFO storage, the timer and DMA sit outside and use the values and strobes this block provides.

A bank-select bit in the main configuration register changes the meaning of the three lowest write offsets. With bank 2 selected, those offsets stop writing the port and configuration registers and become clear strobes for the terminal-count, interrupt-1 and interrupt-2 flags. The same bit decides where the first channel offset goes. In bank 1 a write there is sent to the FIFO through a valid/ready stream port. In bank 2 it loads channel 0 directly.

The stream port holds one word. When the host writes the FIFO port, the word is offered with `fifo_tvalid` high. It stays unchanged until the sink raises `fifo_tready`. The host bus cannot be stalled, so a write that arrives while a word is still waiting is discarded. A write that arrives while the FIFO is disabled is also discarded.

Top module: `aoctl_regfile`

## Requirements
- R1: After reset all configuration, port and channel registers are zero, bank 1 is selected, all event flags are clear and `fifo_tvalid` is low.
- R2: A write to offset 0x0A loads the main configuration register in either bank. Bits 3..0 appear on `cfg_chan`, bit 8 appears on `cfg_fifo_en`, and bit 7 selects bank 2.
- R3: A read of offset 0x0A returns the status word: bit 6 FIFO half-full, bit 5 FIFO empty, bit 4 FIFO full, bit 3 interrupt-2 flag, bit 2 interrupt-1 flag, bit 1 terminal-count flag, and all other bits zero.
- R4: A one-cycle pulse on an event input sets its flag in the next cycle. The flag stays set until a bank-2 write clears it: offset 0x00 clears terminal-count, 0x02 clears interrupt 1, 0x04 clears interrupt 2. When a set and a clear occur in the same cycle, the flag ends up set.
- R5: In bank 1, writes to 0x00, 0x02 and 0x04 load the digital port, the calibration control register and the auxiliary configuration register, and they clear no flag. In bank 2 these writes leave all three registers unchanged.
- R6: For channels n of 1 and above, a write to offset 0x0C+2n stores `bus_wdata[11:0]` (a two's-complement code) on channel n in either bank. A read of that offset returns the code zero-extended to 16 bits. With no write, the channel holds its value.
- R7: In bank 2 a write to 0x0C loads channel 0. In bank 1 that write goes to the FIFO port and channel 0 keeps its value.
- R8: A bank-1 write to 0x0C while the FIFO is enabled and no word is waiting, or while the waiting word is being accepted, presents the write data on `fifo_tdata` with `fifo_tvalid` high in the next cycle. The data stays there until `fifo_tready` is high. A write made while a word is stalled, or while the FIFO is disabled, is discarded.
- R9: A read of 0x0C returns zero and raises `fifo_clear` for exactly the following cycle.
- R10: `dio_oe[3:0]` follows auxiliary configuration bit 2 and `dio_oe[7:4]` follows bit 3. `dio_out` holds the last bank-1 write to 0x00. A read of 0x00 returns `dio_in` in bits 7..0.
- R11: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_addr | input | 5 | Byte offset within the window (bit 0 ignored) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| bus_rvalid | output | 1 | High when bus_rdata carries the previous read |
| dio_in | input | 8 | Digital port input levels |
| dio_out | output | 8 | Digital port output levels |
| dio_oe | output | 8 | Per-bit output drive enable |
| cfg_chan | output | 4 | Channel field of the main configuration |
| cfg_fifo_en | output | 1 | FIFO enable from the main configuration |
| cal_ctrl | output | 16 | Calibration control register contents |
| fifo_half | input | 1 | FIFO half-full level |
| fifo_empty | input | 1 | FIFO empty level |
| fifo_full | input | 1 | FIFO full level |
| ev_tc_set | input | 1 | Terminal-count event pulse |
| ev_int1_set | input | 1 | Interrupt-1 event pulse |
| ev_int2_set | input | 1 | Interrupt-2 event pulse |
| irq_tc | output | 1 | Terminal-count flag |
| irq_int1 | output | 1 | Interrupt-1 flag |
| irq_int2 | output | 1 | Interrupt-2 flag |
| fifo_tdata | output | 16 | Stream data toward the FIFO |
| fifo_tvalid | output | 1 | Stream word valid |
| fifo_tready | input | 1 | Stream sink ready |
| fifo_clear | output | 1 | One-cycle FIFO flush request |
| ch_data | output | 120 | Channel codes, 12 bits per channel, channel 0 in the low bits |

## Verification
The assertions check on every cycle that an event flag follows its set pulse and is held until its clear, and that a stalled stream word keeps both its valid and its data. They also check that a channel register does not move without a write, that a bank-2 write never alters the auxiliary configuration, that a flush follows each read of the FIFO offset, and that read data follows each read. Only the bench's scenarios can show the rest: the offset map in each bank, the status bit layout, the discarding of writes while the port is stalled or disabled, and the nibble drive enables on the digital port.

// File: rtl/aoctl_pkg.sv
package aoctl_pkg;

  // Word index = byte offset >> 1; decoding depends on these positions.
  localparam int            WIDX_W   = 4;
  localparam logic [3:0]    W_DIO    = 4'd0;
  localparam logic [3:0]    W_CAL    = 4'd1;
  localparam logic [3:0]    W_AUX    = 4'd2;
  localparam logic [3:0]    W_MAIN   = 4'd5;
  localparam logic [3:0]    W_CH0    = 4'd6;

  // Main configuration bit positions
  localparam int MAIN_BANK   = 7;
  localparam int MAIN_FIFOEN = 8;
  localparam int MAIN_CHAN_W = 4;

  // Auxiliary configuration bit positions
  localparam int AUX_OE_LO = 2;
  localparam int AUX_OE_HI = 3;

  // Event flag indices
  localparam int EV_TC   = 0;
  localparam int EV_INT1 = 1;
  localparam int EV_INT2 = 2;
  localparam int NEV     = 3;

  typedef struct packed {
    logic           dio_wr;
    logic           cal_wr;
    logic           aux_wr;
    logic           main_wr;
    logic           fifo_wr;
    logic           fifo_rd;
    logic [NEV-1:0] ev_clr;
  } strobe_t;

endpackage

// File: rtl/aoctl_decode.sv
module aoctl_decode
  import aoctl_pkg::*;
#(
  parameter int NCH = 10
) (
  input  logic              wr,
  input  logic              rd,
  input  logic              bank2,
  input  logic [WIDX_W-1:0] widx,
  output strobe_t           stb,
  output logic [NCH-1:0]    ch_wr
);

  always_comb begin
    stb = '0;
    if (wr) begin
      case (widx)
        W_DIO:  if (bank2) stb.ev_clr[EV_TC]   = 1'b1; else stb.dio_wr = 1'b1;
        W_CAL:  if (bank2) stb.ev_clr[EV_INT1] = 1'b1; else stb.cal_wr = 1'b1;
        W_AUX:  if (bank2) stb.ev_clr[EV_INT2] = 1'b1; else stb.aux_wr = 1'b1;
        W_MAIN: stb.main_wr = 1'b1;
        W_CH0:  if (!bank2) stb.fifo_wr = 1'b1;
        default: ;
      endcase
    end
    if (rd && widx == W_CH0) stb.fifo_rd = 1'b1;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_chdec
    if (n == 0) begin : g_first
      assign ch_wr[n] = wr && bank2 && (widx == W_CH0);
    end else begin : g_rest
      assign ch_wr[n] = wr && (widx == W_CH0 + WIDX_W'(n));
    end
  end

endmodule

// File: rtl/aoctl_evflags.sv
module aoctl_evflags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)      q <= 1'b0;
      else if (set[i]) q <= 1'b1;
      else if (clr[i]) q <= 1'b0;
    end
    assign flag[i] = q;

    // R4: a set pulse always leaves the flag high, even against a clear
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag[i]);
    // R4: a set flag holds until its clear strobe
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr[i]) |=> flag[i]);
  end

endmodule

// File: rtl/aoctl_chreg.sv
module aoctl_chreg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= din;
  end

  // R6: without a write the code is held
  p_ch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));

endmodule

// File: rtl/aoctl_fifo_port.sv
module aoctl_fifo_port #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] tdata,
  output logic          tvalid,
  input  logic          tready
);

  logic take;
  assign take = load && en && (!tvalid || tready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tvalid <= 1'b0;
      tdata  <= '0;
    end else if (take) begin
      tvalid <= 1'b1;
      tdata  <= din;
    end else if (tready) begin
      tvalid <= 1'b0;
    end
  end

  // R8: a stalled word keeps valid and data
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && !tready) |=> (tvalid && $stable(tdata)));
  // R8: nothing appears without an enabled load
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tvalid && !(load && en)) |=> !tvalid);

endmodule

// File: rtl/aoctl_regfile.sv
module aoctl_regfile
  import aoctl_pkg::*;
#(
  parameter int NCH = 10,  // at most 10 channels fit the window
  parameter int CHW = 12,
  parameter int DW  = 16,
  parameter int AW  = 5,
  parameter int PW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_rvalid,
  input  logic [PW-1:0]  dio_in,
  output logic [PW-1:0]  dio_out,
  output logic [PW-1:0]  dio_oe,
  output logic [MAIN_CHAN_W-1:0] cfg_chan,
  output logic           cfg_fifo_en,
  output logic [DW-1:0]  cal_ctrl,
  input  logic           fifo_half,
  input  logic           fifo_empty,
  input  logic           fifo_full,
  input  logic           ev_tc_set,
  input  logic           ev_int1_set,
  input  logic           ev_int2_set,
  output logic           irq_tc,
  output logic           irq_int1,
  output logic           irq_int2,
  output logic [DW-1:0]  fifo_tdata,
  output logic           fifo_tvalid,
  input  logic           fifo_tready,
  output logic           fifo_clear,
  output logic [NCH*CHW-1:0] ch_data
);

  localparam int HALF = PW / 2;

  logic [WIDX_W-1:0] widx;
  logic [DW-1:0]     main_q, aux_q, cal_q;
  logic [PW-1:0]     dio_q;
  logic              bank2;
  strobe_t           stb;
  logic [NCH-1:0]    ch_wr;
  logic [NEV-1:0]    ev_set, ev_flag;
  logic [DW-1:0]     rd_mux;

  assign widx  = bus_addr[AW-1:1];
  assign bank2 = main_q[MAIN_BANK];

  aoctl_decode #(.NCH(NCH)) u_dec (
    .wr(bus_wr), .rd(bus_rd), .bank2(bank2), .widx(widx),
    .stb(stb), .ch_wr(ch_wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_q <= '0;
      aux_q  <= '0;
      cal_q  <= '0;
      dio_q  <= '0;
    end else begin
      if (stb.main_wr) main_q <= bus_wdata;
      if (stb.aux_wr)  aux_q  <= bus_wdata;
      if (stb.cal_wr)  cal_q  <= bus_wdata;
      if (stb.dio_wr)  dio_q  <= bus_wdata[PW-1:0];
    end
  end

  assign cfg_chan    = main_q[MAIN_CHAN_W-1:0];
  assign cfg_fifo_en = main_q[MAIN_FIFOEN];
  assign cal_ctrl    = cal_q;
  assign dio_out     = dio_q;
  assign dio_oe      = {{(PW-HALF){aux_q[AUX_OE_HI]}}, {HALF{aux_q[AUX_OE_LO]}}};

  assign ev_set[EV_TC]   = ev_tc_set;
  assign ev_set[EV_INT1] = ev_int1_set;
  assign ev_set[EV_INT2] = ev_int2_set;

  aoctl_evflags #(.N(NEV)) u_ev (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(stb.ev_clr), .flag(ev_flag)
  );

  assign irq_tc   = ev_flag[EV_TC];
  assign irq_int1 = ev_flag[EV_INT1];
  assign irq_int2 = ev_flag[EV_INT2];

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    aoctl_chreg #(.W(CHW)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr(ch_wr[n]),
      .din(bus_wdata[CHW-1:0]), .q(ch_data[n*CHW +: CHW])
    );
  end

  aoctl_fifo_port #(.DW(DW)) u_fp (
    .clk(clk), .rst_n(rst_n), .load(stb.fifo_wr), .en(cfg_fifo_en),
    .din(bus_wdata), .tdata(fifo_tdata), .tvalid(fifo_tvalid),
    .tready(fifo_tready)
  );

  always_comb begin
    rd_mux = '0;
    case (widx)
      W_DIO:  rd_mux[PW-1:0] = dio_in;
      W_CAL:  rd_mux = cal_q;
      W_AUX:  rd_mux = aux_q;
      W_MAIN: rd_mux[6:0] = {fifo_half, fifo_empty, fifo_full,
                             ev_flag[EV_INT2], ev_flag[EV_INT1],
                             ev_flag[EV_TC], 1'b0};
      default: ;
    endcase
    for (int n = 1; n < NCH; n++) begin
      if (widx == W_CH0 + WIDX_W'(n)) rd_mux[CHW-1:0] = ch_data[n*CHW +: CHW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      fifo_clear <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      fifo_clear <= stb.fifo_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  // R5: a bank-2 write at the auxiliary offset leaves it untouched
  p_bank2_keeps_aux_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bank2 && widx == W_AUX) |=> $stable(aux_q));
  // R9: reading the FIFO offset flushes and returns zero
  p_rd_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && widx == W_CH0) |=> (fifo_clear && bus_rdata == '0));
  // R11: every read is answered in the next cycle
  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

endmodule

// File: tb/aoctl_regfile_test.sv
`timescale 1ns/1ps
module aoctl_regfile_test;

  localparam int NCH = 10;
  localparam int CHW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic bus_rvalid;
  logic [7:0] dio_in = '0, dio_out, dio_oe;
  logic [3:0] cfg_chan;
  logic cfg_fifo_en;
  logic [15:0] cal_ctrl;
  logic fifo_half = 0, fifo_empty = 0, fifo_full = 0;
  logic ev_tc_set = 0, ev_int1_set = 0, ev_int2_set = 0;
  logic irq_tc, irq_int1, irq_int2;
  logic [15:0] fifo_tdata;
  logic fifo_tvalid;
  logic fifo_tready = 0;
  logic fifo_clear;
  logic [NCH*CHW-1:0] ch_data;

  always #2.5 clk = ~clk;

  aoctl_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .dio_in(dio_in), .dio_out(dio_out),
    .dio_oe(dio_oe), .cfg_chan(cfg_chan), .cfg_fifo_en(cfg_fifo_en),
    .cal_ctrl(cal_ctrl), .fifo_half(fifo_half), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .ev_tc_set(ev_tc_set), .ev_int1_set(ev_int1_set),
    .ev_int2_set(ev_int2_set), .irq_tc(irq_tc), .irq_int1(irq_int1),
    .irq_int2(irq_int2), .fifo_tdata(fifo_tdata), .fifo_tvalid(fifo_tvalid),
    .fifo_tready(fifo_tready), .fifo_clear(fifo_clear), .ch_data(ch_data)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [15:0] st_exp_q[$];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // read scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (rd_exp_q.size() == 0) chk("R11 unexpected read data", 32'(bus_rdata), 32'hFFFF_FFFF);
      else chk(rd_tag_q.pop_front(), 32'(bus_rdata), 32'(rd_exp_q.pop_front()));
    end
  end

  // stream scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && fifo_tvalid && fifo_tready) begin
      if (st_exp_q.size() == 0) chk("R8 unexpected stream word", 32'(fifo_tdata), 32'hFFFF_FFFF);
      else chk("R8 stream word", 32'(fifo_tdata), 32'(st_exp_q.pop_front()));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    rd_exp_q.push_back(exp);
    rd_tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_rd = 1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  function automatic logic [11:0] ch(input int n);
    return ch_data[n*CHW +: CHW];
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    chk("R1 channels zero", 32'(ch_data == '0), 32'd1);
    chk("R1 oe zero", 32'(dio_oe), 32'h0);
    chk("R1 flags clear", 32'({irq_tc, irq_int1, irq_int2}), 32'h0);
    chk("R1 stream idle", 32'(fifo_tvalid), 32'h0);
    chk("R1 chan field", 32'(cfg_chan), 32'h0);
    fifo_empty = 1;
    rd(5'h0A, 16'h0020, "R3 status after reset");
    fifo_empty = 0;

    // R10 digital port and drive enables
    wr(5'h04, 16'h0004);
    chk("R10 low nibble oe", 32'(dio_oe), 32'h0F);
    wr(5'h04, 16'h000C);
    chk("R10 both nibbles oe", 32'(dio_oe), 32'hFF);
    wr(5'h00, 16'h00A5);
    chk("R10 dio_out", 32'(dio_out), 32'hA5);
    dio_in = 8'h3C;
    rd(5'h00, 16'h003C, "R10 dio_in readback");
    rd(5'h04, 16'h000C, "R5 aux readback");
    wr(5'h02, 16'h1234);
    chk("R5 cal register", 32'(cal_ctrl), 32'h1234);

    // R6 channel registers
    wr(5'h0E, 16'hF123);
    chk("R6 ch1 code", 32'(ch(1)), 32'h123);
    rd(5'h0E, 16'h0123, "R6 ch1 readback");
    wr(5'h1E, 16'h0800);
    chk("R6 ch9 code", 32'(ch(9)), 32'h800);
    rd(5'h1E, 16'h0800, "R6 ch9 readback");
    chk("R6 ch1 held", 32'(ch(1)), 32'h123);

    // R2 main config, R7/R8 stream port in bank 1
    wr(5'h0A, 16'h0105);
    chk("R2 chan field", 32'(cfg_chan), 32'h5);
    chk("R2 fifo enable", 32'(cfg_fifo_en), 32'h1);
    st_exp_q.push_back(16'h0ABC);
    wr(5'h0C, 16'h0ABC);
    chk("R8 word offered", 32'(fifo_tvalid), 32'h1);
    chk("R7 ch0 untouched in bank 1", 32'(ch(0)), 32'h0);
    wr(5'h0C, 16'h0111);
    chk("R8 stalled data held", 32'(fifo_tdata), 32'h0ABC);
    @(posedge clk); #1 fifo_tready = 1;
    @(posedge clk); #1;
    chk("R8 accepted", 32'(fifo_tvalid), 32'h0);
    wr(5'h0A, 16'h0000);
    wr(5'h0C, 16'h0222);
    chk("R8 disabled write dropped", 32'(fifo_tvalid), 32'h0);

    // R4/R5 event flags and banking
    @(posedge clk); #1 ev_int1_set = 1;
    @(posedge clk); #1 ev_int1_set = 0;
    chk("R4 int1 set", 32'(irq_int1), 32'h1);
    wr(5'h02, 16'h0000);
    chk("R5 bank-1 write keeps int1", 32'(irq_int1), 32'h1);
    wr(5'h0A, 16'h0080);
    wr(5'h04, 16'h0000);
    chk("R5 bank 2 keeps oe", 32'(dio_oe), 32'hFF);
    wr(5'h00, 16'h0000);
    chk("R5 bank 2 keeps dio_out", 32'(dio_out), 32'hA5);
    wr(5'h02, 16'h0000);
    chk("R5 bank 2 keeps cal", 32'(cal_ctrl), 32'h0000);
    chk("R4 int1 cleared", 32'(irq_int1), 32'h0);
    @(posedge clk); #1;
    ev_tc_set = 1; bus_wr = 1; bus_addr = 5'h00; bus_wdata = '0;
    @(posedge clk); #1;
    ev_tc_set = 0; bus_wr = 0;
    chk("R4 set wins over clear", 32'(irq_tc), 32'h1);
    wr(5'h00, 16'h0000);
    chk("R4 tc cleared", 32'(irq_tc), 32'h0);
    @(posedge clk); #1 ev_int2_set = 1;
    @(posedge clk); #1 ev_int2_set = 0;
    fifo_half = 1; fifo_full = 1;
    rd(5'h0A, 16'h0058, "R3 status layout");
    fifo_half = 0; fifo_full = 0;
    wr(5'h04, 16'h0000);
    chk("R4 int2 cleared", 32'(irq_int2), 32'h0);

    // R7 channel 0 in bank 2
    wr(5'h0C, 16'h0F80);
    chk("R7 ch0 loaded in bank 2", 32'(ch(0)), 32'hF80);
    chk("R7 no stream word in bank 2", 32'(fifo_tvalid), 32'h0);

    // R9 flush on read
    rd(5'h0C, 16'h0000, "R9 read of fifo offset");
    chk("R9 flush pulse", 32'(fifo_clear), 32'h1);
    @(posedge clk); #1;
    chk("R9 flush one cycle", 32'(fifo_clear), 32'h0);

    repeat (3) @(posedge clk); #1;
    chk("R11 all reads answered", 32'(rd_exp_q.size()), 32'h0);
    chk("R8 all stream words seen", 32'(st_exp_q.size()), 32'h0);
    done = 1;
    summary();
    $finish;
  end

endmodule